// File: doc/BRIEF.md
# Memory-Mapped Address Decoder with Latching Parallel Output Ports

This block sits on a 16-bit address, 8-bit data processor bus as a slave. It decodes the address into select lines for two external memory regions, a 2 KiB read-only region at the bottom of the map and a 2 KiB read-write region at the half-way point. It also decodes a four-byte window at the very top of the map, where it implements a small parallel output peripheral itself. The memories behind the two selects live outside the block.

The peripheral holds four 8-bit registers. Three of them drive the output port buses A, B and C. The fourth is a control byte that software can write and read back. A written value stays on its port until the same register is written again or reset is applied. Reads of the window return the addressed register on the read-data bus. In every other case the read-data bus is zero, so it can be ORed into a shared return path. The bus is a plain strobe interface with no back-pressure: every access finishes in the cycle it is presented, so there is no valid/ready handshake.

Top module: `mmio_pio_top`

## Requirements
- R1: `rom_sel` is high exactly when `addr` lies in 0000h–07FFh. It depends only on `addr`, not on `rd` or `wr`.
- R2: `ram_sel` is high exactly when `addr` lies in 8000h–87FFh. It depends only on `addr`.
- R3: The peripheral window is FFFCh–FFFFh. No address asserts more than one of ROM select, RAM select and window select. Addresses outside all three regions (for example 0800h, 7FFFh, 8800h, FFFBh) assert none of them.
- R4: On a rising clock edge where `addr` is in the window and `wr` is high, `wdata` is stored in the register chosen by `addr[1:0]`. The codes are 00 for port A, 01 for port B, 10 for port C and 11 for the control register.
- R5: A port keeps its value until its own register is written. Writes to other registers, edges with `wr` low, and writes with `wr` high to addresses outside the window (including addresses whose low two bits match a port) leave it unchanged.
- R6: While `rd` is high and `addr` is in the window, `rdata` shows the current value of the register chosen by `addr[1:0]`, in the same cycle. This includes the control register at code 11.
- R7: `rdata` is 00h whenever `rd` is low or `addr` is outside the window.
- R8: While `rst` is high at a clock edge, all four registers are cleared to 00h. This applies both at start-up and when reset is applied in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| rdata | output | 8 | Read data, 00h when not reading the window |
| rom_sel | output | 1 | Select for the read-only region |
| ram_sel | output | 1 | Select for the read-write region |
| port_a | output | 8 | Output port A |
| port_b | output | 8 | Output port B |
| port_c | output | 8 | Output port C |

## Verification
The decoder is tested with addresses on both sides of every region edge, such as 07FFh against 0800h, 87FFh against 8800h, and FFFBh against FFFCh. These pairs catch an off-by-one in the width of a region's compare. The register block is tested with a distinct byte written to each of the four codes, so that a swapped index shows up as a wrong port or a wrong readback. A single later write to one port checks that its neighbours keep their values. Writes outside the window use low bits that match port A, and a hold period keeps `wdata` changing while `wr` is low. These show whether the window gating or the strobe gating is missing. Reset is applied in the middle of a run, after nonzero values are loaded, to show that it really clears the registers.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned IDX_W    = 2;
  localparam int unsigned NREG     = 2 ** IDX_W;
  localparam int unsigned MEM_SPAN = 11;

  localparam logic [ADDR_W-1:0] ROM_BASE = 16'h0000;
  localparam logic [ADDR_W-1:0] RAM_BASE = 16'h8000;
  localparam logic [ADDR_W-1:0] PIO_BASE = 16'hFFFC;

  typedef enum logic [IDX_W-1:0] {
    REG_PORT_A = 2'd0,
    REG_PORT_B = 2'd1,
    REG_PORT_C = 2'd2,
    REG_CTRL   = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/mmio_region_match.sv
module mmio_region_match #(
  parameter int unsigned              AW     = 16,
  parameter int unsigned              SPAN_W = 11,
  parameter logic [AW-1:0]            BASE   = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int unsigned TAG_W = AW - SPAN_W;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE[AW-1:SPAN_W];

  always_comb begin
    hit = (addr[AW-1:SPAN_W] == BASE_TAG);
  end
endmodule

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              pio_sel
);
  localparam int unsigned NREGION = 3;
  localparam logic [NREGION-1:0][ADDR_W-1:0] BASES = {PIO_BASE, RAM_BASE, ROM_BASE};
  localparam int unsigned SPANS [NREGION] = '{MEM_SPAN, MEM_SPAN, IDX_W};

  logic [NREGION-1:0] hits;

  for (genvar g = 0; g < NREGION; g++) begin : g_region
    mmio_region_match #(
      .AW    (ADDR_W),
      .SPAN_W(SPANS[g]),
      .BASE  (BASES[g])
    ) u_match (
      .addr(addr),
      .hit (hits[g])
    );
  end

  always_comb begin
    rom_sel = hits[0];
    ram_sel = hits[1];
    pio_sel = hits[2];
  end
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
  import mmio_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NREG-1:0][DATA_W-1:0] regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (we && (idx == IDX_W'(g))) begin
        regs[g] <= wdata;
      end
    end

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
      (we && idx == IDX_W'(g)) |=> (regs[g] == $past(wdata)));

    assert_hold_value_R5: assert property (@(posedge clk) disable iff (rst)
      !(we && idx == IDX_W'(g)) |=> $stable(regs[g]));
  end
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
  import mmio_pkg::*;
(
  input  logic                        en,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NREG-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (en && (idx == IDX_W'(i))) rdata = regs[i];
    end
  end
endmodule

// File: rtl/mmio_pio_top.sv
module mmio_pio_top
  import mmio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       addr,
  input  logic [7:0]        wdata,
  input  logic              rd,
  input  logic              wr,
  output logic [7:0]        rdata,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic [7:0]        port_a,
  output logic [7:0]        port_b,
  output logic [7:0]        port_c
);
  logic                        pio_sel;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [IDX_W-1:0]            idx;

  assign idx = addr[IDX_W-1:0];

  mmio_decode u_decode (
    .addr   (addr),
    .rom_sel(rom_sel),
    .ram_sel(ram_sel),
    .pio_sel(pio_sel)
  );

  pio_regfile u_regs (
    .clk  (clk),
    .rst  (rst),
    .we   (pio_sel && wr),
    .idx  (idx),
    .wdata(wdata),
    .regs (regs)
  );

  pio_rdmux u_rdmux (
    .en   (pio_sel && rd),
    .idx  (idx),
    .regs (regs),
    .rdata(rdata)
  );

  assign port_a = regs[REG_PORT_A];
  assign port_b = regs[REG_PORT_B];
  assign port_c = regs[REG_PORT_C];

  assert_single_select_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_sel, ram_sel, pio_sel}));

  assert_rom_window_R1: assert property (@(posedge clk) disable iff (rst)
    rom_sel |-> (addr < 16'h0800));

  assert_ram_window_R2: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> (addr >= 16'h8000 && addr < 16'h8800));

  assert_idle_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !(rd && addr >= 16'hFFFC) |-> (rdata == 8'h00));

  assert_ctrl_readback_R6: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == 16'hFFFF) |-> (rdata == regs[REG_CTRL]));
endmodule

// File: tb/tb_mmio_pio_top.sv
`timescale 1ns/1ps
module tb_mmio_pio_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h4000;
  logic [7:0]  wdata = 8'h00;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  rdata;
  logic        rom_sel, ram_sel;
  logic [7:0]  port_a, port_b, port_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  mmio_pio_top dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
    .rdata(rdata), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .port_a(port_a), .port_b(port_b), .port_c(port_c)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected read result per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(rdata, e.val, e.tag);
    end
  end

  task automatic bus_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    addr = a; rd = 1'b1;
    exp_q.push_back('{val: exp, tag: tag});
    @(posedge clk); #1;
    rd = 1'b0; addr = 16'h4000;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0; addr = 16'h4000;
  endtask

  task automatic chk_sel(input logic [15:0] a, input logic r, input logic m, input string tag);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk({7'd0, rom_sel}, {7'd0, r}, tag);
    chk({7'd0, ram_sel}, {7'd0, m}, tag);
  endtask

  task automatic chk_ports(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input string tag);
    @(negedge clk);
    chk(port_a, a, {tag, " port_a"});
    chk(port_b, b, {tag, " port_b"});
    chk(port_c, c, {tag, " port_c"});
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R8 reset state
    chk_ports(8'h00, 8'h00, 8'h00, "R8 reset");
    bus_read(16'hFFFF, 8'h00, "R8 ctrl after reset");

    // R1 / R2 / R3 decode boundaries
    chk_sel(16'h0000, 1'b1, 1'b0, "R1 rom low edge");
    chk_sel(16'h07FF, 1'b1, 1'b0, "R1 rom high edge");
    chk_sel(16'h0800, 1'b0, 1'b0, "R3 above rom");
    chk_sel(16'h7FFF, 1'b0, 1'b0, "R3 below ram");
    chk_sel(16'h8000, 1'b0, 1'b1, "R2 ram low edge");
    chk_sel(16'h87FF, 1'b0, 1'b1, "R2 ram high edge");
    chk_sel(16'h8800, 1'b0, 1'b0, "R3 above ram");
    chk_sel(16'hFFFC, 1'b0, 1'b0, "R3 window no mem select");
    @(posedge clk); #1 addr = 16'h0100; rd = 1'b1; wr = 1'b0;
    @(negedge clk) chk({7'd0, rom_sel}, 8'h01, "R1 select with rd high");
    @(posedge clk); #1 rd = 1'b0;

    // R4 writes to each code
    bus_write(16'hFFFC, 8'h5A);
    bus_write(16'hFFFD, 8'hC3);
    bus_write(16'hFFFE, 8'h0F);
    bus_write(16'hFFFF, 8'h81);
    chk_ports(8'h5A, 8'hC3, 8'h0F, "R4 all ports");

    // R6 readback
    bus_read(16'hFFFC, 8'h5A, "R6 read A");
    bus_read(16'hFFFD, 8'hC3, "R6 read B");
    bus_read(16'hFFFE, 8'h0F, "R6 read C");
    bus_read(16'hFFFF, 8'h81, "R6 read ctrl");

    // R7 reads that return zero
    bus_read(16'hFFFB, 8'h00, "R7 read just below window");
    bus_read(16'h8000, 8'h00, "R7 read ram region");
    @(posedge clk); #1 addr = 16'hFFFC; rd = 1'b0;
    @(negedge clk) chk(rdata, 8'h00, "R7 rd low in window");

    // R5 neighbours keep value
    bus_write(16'hFFFD, 8'h77);
    chk_ports(8'h5A, 8'h77, 8'h0F, "R5 single rewrite");
    // R5 writes outside the window
    bus_write(16'hFFF8, 8'hEE);
    bus_write(16'h8000, 8'hEE);
    bus_write(16'h0002, 8'hEE);
    chk_ports(8'h5A, 8'h77, 8'h0F, "R5 outside writes");
    bus_read(16'hFFFF, 8'h81, "R5 ctrl after outside writes");
    // R5 hold with wr low while wdata moves
    @(posedge clk); #1 addr = 16'hFFFC;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1 wdata = 8'(i * 37 + 1);
    end
    #1 addr = 16'h4000;
    chk_ports(8'h5A, 8'h77, 8'h0F, "R5 hold wr low");

    // R8 mid-run reset
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    chk_ports(8'h00, 8'h00, 8'h00, "R8 mid-run reset");
    bus_read(16'hFFFF, 8'h00, "R8 ctrl cleared");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule